// File: doc/BRIEF.md
# Atomic memory operation unit

This block sits in front of a small single-ported data memory and serves several requesters. Each request carries an operation code, a word address and two operands. Plain loads and stores are supported, along with four atomic primitives: compare-and-swap, test-and-set, fetch-and-increment, and a linked-load / conditional-store pair. A single engine performs every operation as a read-modify-write. That engine holds only one request at a time, so no other access to memory can come between the read and the write of an atomic.

Requesters present a request with a valid/ready handshake. A round-robin arbiter picks one of the asserted requesters when the engine is idle. The operation runs in the next cycle, and the block returns a one-cycle response with the requester's index, a data word and a success flag.

Each requester owns one link reservation, made of a valid bit and an address. A linked load sets it. A successful write by any requester to that address clears it. The owner's conditional store also clears it, whether the store succeeds or fails.

Top module: `amo_unit`

## Requirements
- R1: A load (op code 0) returns the addressed word with ok=1. A store (op code 1) writes operand A and responds with data 0 and ok=1. A store to one address leaves every other address unchanged.
- R2: Compare-and-swap (op code 2) returns the old word. When the old word equals operand A, it writes operand B and sets ok=1. Otherwise memory is unchanged and ok=0.
- R3: Test-and-set (op code 3) writes operand A and returns the previous word with ok=1.
- R4: Fetch-and-increment (op code 4) writes the old word plus one, modulo 2^DATA_W, and returns the old word with ok=1.
- R5: After a linked load (op code 5, which returns the word) by requester k, a conditional store (op code 6) by k to the same address succeeds if no write to that address came between them. On success it writes operand A and responds with data 1 and ok=1.
- R6: A conditional store fails, responding with data 0 and ok=0 and leaving memory unchanged, in two cases: when another requester wrote the linked address after the linked load, or when the requester holds no reservation for that address.
- R7: A conditional store clears its own requester's reservation, so a second conditional store without a new linked load fails. A write to a different address does not clear a reservation.
- R8: At most one requester's ready is high in any cycle, and only while the engine is idle. An accepted request gets exactly one one-cycle response, two cycles after the accepting cycle. No request is accepted in the cycle after an acceptance.
- R9: Ready is only given to a requester whose valid is high. With several requesters waiting, grants rotate in increasing index order starting after the last granted requester, and rsp_id names the requester whose request was accepted.
- R10: After reset, rsp_valid is low, no ready is high without a request, and no reservation is held, so a conditional store fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_REQ | Request valid, one bit per requester |
| req_ready | output | N_REQ | Request accepted this cycle, one bit per requester |
| req_op | input | N_REQ*3 | Operation code per requester (0 load, 1 store, 2 compare-and-swap, 3 test-and-set, 4 fetch-and-increment, 5 linked load, 6 conditional store) |
| req_addr | input | N_REQ*ADDR_W | Word address per requester |
| req_opa | input | N_REQ*DATA_W | Operand A per requester (store data, compare value, set value) |
| req_opb | input | N_REQ*DATA_W | Operand B per requester (swap value) |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_id | output | $clog2(N_REQ) | Index of the requester being answered |
| rsp_data | output | DATA_W | Old word, or 1/0 for a conditional store, or 0 for a store |
| rsp_ok | output | 1 | Success flag |

## Verification
On every cycle, the assertions check the handshake and serialization rules: ready is one-hot, ready follows valid, no request is accepted right after another, and each acceptance is followed by exactly one pulse with the fixed two-cycle latency and the accepted requester's index. They also check that a conditional store's response is a clean 1/0 that agrees with its ok flag. The values stored by each atomic need directed scenarios that read memory back. So do the reservation rules, where an intervening write by another requester, a write to a different address, and a repeated conditional store each give a different outcome, and so does the rotation order of grants.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_CAS   = 3'd2,
    OP_TAS   = 3'd3,
    OP_FAI   = 3'd4,
    OP_LL    = 3'd5,
    OP_SC    = 3'd6
  } amo_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } amo_st_e;
endpackage

// File: rtl/amo_rr_arb.sv
module amo_rr_arb #(
  parameter int N_REQ = 4,
  localparam int ID_W = $clog2(N_REQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] grant,
  output logic [ID_W-1:0]  gnt_idx
);
  logic [ID_W-1:0] ptr_q, ptr_d;
  logic            found;
  int              cand;

  always_comb begin
    grant   = '0;
    gnt_idx = '0;
    found   = 1'b0;
    cand    = 0;
    for (int off = 1; off <= N_REQ; off++) begin
      cand = int'(ptr_q) + off;
      if (cand >= N_REQ) cand = cand - N_REQ;
      if (en && !found && req[cand]) begin
        found       = 1'b1;
        grant[cand] = 1'b1;
        gnt_idx     = ID_W'(cand);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (found) ptr_d = gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= ID_W'(N_REQ - 1);
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 4,
  localparam int ID_W  = $clog2(N_REQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_set,
  input  logic              own_clr,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   id,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [N_REQ-1:0]  v_q, v_d;
  logic [ADDR_W-1:0] a_q [N_REQ];
  logic [ADDR_W-1:0] a_d [N_REQ];

  for (genvar i = 0; i < N_REQ; i++) begin : g_slot
    always_comb begin
      v_d[i] = v_q[i];
      a_d[i] = a_q[i];
      if (link_set && id == ID_W'(i)) begin
        v_d[i] = 1'b1;
        a_d[i] = addr;
      end else if ((own_clr && id == ID_W'(i)) ||
                   (wr_en && v_q[i] && a_q[i] == addr)) begin
        v_d[i] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[i] <= 1'b0;
        a_q[i] <= '0;
      end else begin
        v_q[i] <= v_d[i];
        a_q[i] <= a_d[i];
      end
    end
  end

  assign hit = v_q[id] && (a_q[id] == addr);
endmodule

// File: rtl/amo_mem.sv
module amo_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int ID_W  = $clog2(N_REQ)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_REQ-1:0]        req_valid,
  output logic [N_REQ-1:0]        req_ready,
  input  logic [N_REQ*OP_W-1:0]   req_op,
  input  logic [N_REQ*ADDR_W-1:0] req_addr,
  input  logic [N_REQ*DATA_W-1:0] req_opa,
  input  logic [N_REQ*DATA_W-1:0] req_opb,
  output logic                    rsp_valid,
  output logic [ID_W-1:0]         rsp_id,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    rsp_ok
);
  amo_st_e           st_q, st_d;
  logic [N_REQ-1:0]  grant;
  logic [ID_W-1:0]   gnt_idx;
  logic              idle, exec, cap_en;

  amo_op_e           cur_op;
  logic [ID_W-1:0]   cur_id;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_a, cur_b;

  logic [DATA_W-1:0] mem_rd, wr_data, res_data;
  logic              wr_en, res_ok, resv_hit;

  assign idle      = (st_q == ST_IDLE);
  assign exec      = (st_q == ST_EXEC);
  assign cap_en    = idle && (|req_valid);
  assign req_ready = grant;

  amo_rr_arb #(.N_REQ(N_REQ)) arb_i (
    .clk(clk), .rst_n(rst_n), .en(idle), .req(req_valid),
    .grant(grant), .gnt_idx(gnt_idx)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (cap_en) st_d = ST_EXEC;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      cur_op   <= amo_op_e'(req_op[gnt_idx*OP_W +: OP_W]);
      cur_id   <= gnt_idx;
      cur_addr <= req_addr[gnt_idx*ADDR_W +: ADDR_W];
      cur_a    <= req_opa[gnt_idx*DATA_W +: DATA_W];
      cur_b    <= req_opb[gnt_idx*DATA_W +: DATA_W];
    end
  end

  amo_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
    .clk(clk), .we(exec && wr_en), .addr(cur_addr),
    .wdata(wr_data), .rdata(mem_rd)
  );

  amo_resv #(.N_REQ(N_REQ), .ADDR_W(ADDR_W)) resv_i (
    .clk(clk), .rst_n(rst_n),
    .link_set(exec && cur_op == OP_LL),
    .own_clr(exec && cur_op == OP_SC),
    .wr_en(exec && wr_en),
    .id(cur_id), .addr(cur_addr), .hit(resv_hit)
  );

  always_comb begin
    wr_en    = 1'b0;
    wr_data  = cur_a;
    res_data = mem_rd;
    res_ok   = 1'b1;
    case (cur_op)
      OP_STORE: begin
        wr_en    = 1'b1;
        res_data = '0;
      end
      OP_CAS: begin
        res_ok  = (mem_rd == cur_a);
        wr_en   = res_ok;
        wr_data = cur_b;
      end
      OP_TAS: wr_en = 1'b1;
      OP_FAI: begin
        wr_en   = 1'b1;
        wr_data = mem_rd + DATA_W'(1);
      end
      OP_SC: begin
        res_ok      = resv_hit;
        wr_en       = resv_hit;
        res_data    = '0;
        res_data[0] = resv_hit;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= exec;
  end

  always_ff @(posedge clk) begin
    if (exec) begin
      rsp_id   <= cur_id;
      rsp_data <= res_data;
      rsp_ok   <= res_ok;
    end
  end
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk
  import amo_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int DATA_W = 16,
  localparam int ID_W  = $clog2(N_REQ)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_REQ-1:0]  req_valid,
  input logic [N_REQ-1:0]  req_ready,
  input logic              rsp_valid,
  input logic [ID_W-1:0]   rsp_id,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_ok,
  input amo_op_e           cur_op
);
  logic            accept;
  logic [ID_W-1:0] acc_id;

  assign accept = |(req_valid & req_ready);

  always_comb begin
    acc_id = '0;
    for (int i = 0; i < N_REQ; i++)
      if (req_ready[i]) acc_id = ID_W'(i);
  end

  // R8
  ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  // R9
  ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  // R8
  accept_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (req_ready == '0));

  // R8
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 rsp_valid);

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  rsp_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept, 2) |-> (rsp_id == $past(acc_id, 2)));

  // R5
  sc_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && cur_op == OP_SC) |->
      (rsp_data[DATA_W-1:1] == '0 && rsp_ok == rsp_data[0]));

  // R4
  fai_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && cur_op == OP_FAI) |-> rsp_ok);
endmodule

bind amo_unit amo_unit_chk #(.N_REQ(N_REQ), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data),
  .rsp_ok(rsp_ok), .cur_op(cur_op)
);

// File: tb/amo_unit_tb_top.sv
`timescale 1ns/1ps
module amo_unit_tb_top;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int IW = 2;

  logic            clk, rst_n;
  logic [N-1:0]    req_valid;
  logic [N-1:0]    req_ready;
  logic [N*3-1:0]  req_op;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_opa, req_opb;
  logic            rsp_valid;
  logic [IW-1:0]   rsp_id;
  logic [DW-1:0]   rsp_data;
  logic            rsp_ok;

  int n_chk, n_bad;

  amo_unit #(.N_REQ(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data), .rsp_ok(rsp_ok)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input int id, input logic [2:0] op, input logic [AW-1:0] addr,
                        input logic [DW-1:0] a, input logic [DW-1:0] b,
                        output logic [DW-1:0] d, output logic ok);
    @(negedge clk);
    req_op[id*3 +: 3]    = op;
    req_addr[id*AW +: AW] = addr;
    req_opa[id*DW +: DW]  = a;
    req_opb[id*DW +: DW]  = b;
    req_valid[id]         = 1'b1;
    #1;
    while (!req_ready[id]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid[id] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R8 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    check("R9 rsp_id", {30'd0, rsp_id}, id);
    d  = rsp_data;
    ok = rsp_ok;
  endtask

  task automatic t_reset;
    logic [DW-1:0] d; logic ok;
    check("R10 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    check("R10 ready idle", {28'd0, req_ready}, 32'd0);
    run_op(0, 3'd6, 4'd0, 16'h00AA, 16'h0, d, ok);
    check("R10 sc without link data", d, 32'd0);
    check("R10 sc without link ok", ok, 32'd0);
  endtask

  task automatic t_load_store;
    logic [DW-1:0] d; logic ok;
    run_op(0, 3'd1, 4'd3, 16'h1234, 16'h0, d, ok);
    check("R1 store data", d, 32'd0);
    check("R1 store ok", ok, 32'd1);
    run_op(1, 3'd0, 4'd3, 16'h0, 16'h0, d, ok);
    check("R1 load", d, 32'h1234);
    run_op(2, 3'd1, 4'd5, 16'h5A5A, 16'h0, d, ok);
    run_op(3, 3'd0, 4'd3, 16'h0, 16'h0, d, ok);
    check("R1 other address kept", d, 32'h1234);
    run_op(0, 3'd0, 4'd5, 16'h0, 16'h0, d, ok);
    check("R1 second word", d, 32'h5A5A);
  endtask

  task automatic t_cas;
    logic [DW-1:0] d; logic ok;
    run_op(1, 3'd2, 4'd3, 16'h1234, 16'hBEEF, d, ok);
    check("R2 cas hit old", d, 32'h1234);
    check("R2 cas hit ok", ok, 32'd1);
    run_op(0, 3'd0, 4'd3, 16'h0, 16'h0, d, ok);
    check("R2 cas hit wrote", d, 32'hBEEF);
    run_op(2, 3'd2, 4'd3, 16'h1111, 16'h2222, d, ok);
    check("R2 cas miss old", d, 32'hBEEF);
    check("R2 cas miss ok", ok, 32'd0);
    run_op(0, 3'd0, 4'd3, 16'h0, 16'h0, d, ok);
    check("R2 cas miss unchanged", d, 32'hBEEF);
  endtask

  task automatic t_tas;
    logic [DW-1:0] d; logic ok;
    run_op(0, 3'd1, 4'd4, 16'h0000, 16'h0, d, ok);
    run_op(1, 3'd3, 4'd4, 16'h0001, 16'h0, d, ok);
    check("R3 tas first old", d, 32'd0);
    check("R3 tas ok", ok, 32'd1);
    run_op(2, 3'd3, 4'd4, 16'h0001, 16'h0, d, ok);
    check("R3 tas second old", d, 32'd1);
    run_op(3, 3'd0, 4'd4, 16'h0, 16'h0, d, ok);
    check("R3 tas value", d, 32'd1);
  endtask

  task automatic t_fai;
    logic [DW-1:0] d; logic ok;
    run_op(0, 3'd1, 4'd6, 16'hFFFE, 16'h0, d, ok);
    run_op(1, 3'd4, 4'd6, 16'h0, 16'h0, d, ok);
    check("R4 fai old", d, 32'hFFFE);
    check("R4 fai ok", ok, 32'd1);
    run_op(2, 3'd4, 4'd6, 16'h0, 16'h0, d, ok);
    check("R4 fai old at top", d, 32'hFFFF);
    run_op(3, 3'd0, 4'd6, 16'h0, 16'h0, d, ok);
    check("R4 fai wraps", d, 32'h0);
  endtask

  task automatic t_sc_ok;
    logic [DW-1:0] d; logic ok;
    run_op(0, 3'd1, 4'd8, 16'h0055, 16'h0, d, ok);
    run_op(2, 3'd5, 4'd8, 16'h0, 16'h0, d, ok);
    check("R5 ll data", d, 32'h55);
    run_op(2, 3'd6, 4'd8, 16'h0066, 16'h0, d, ok);
    check("R5 sc data", d, 32'd1);
    check("R5 sc ok", ok, 32'd1);
    run_op(1, 3'd0, 4'd8, 16'h0, 16'h0, d, ok);
    check("R5 sc wrote", d, 32'h66);
  endtask

  task automatic t_sc_own;
    logic [DW-1:0] d; logic ok;
    run_op(2, 3'd6, 4'd8, 16'h0077, 16'h0, d, ok);
    check("R7 repeat sc fails", d, 32'd0);
    run_op(1, 3'd0, 4'd8, 16'h0, 16'h0, d, ok);
    check("R7 repeat sc unchanged", d, 32'h66);
    run_op(2, 3'd5, 4'd8, 16'h0, 16'h0, d, ok);
    run_op(1, 3'd1, 4'd9, 16'h0999, 16'h0, d, ok);
    run_op(2, 3'd6, 4'd8, 16'h0088, 16'h0, d, ok);
    check("R7 other-address write keeps link", d, 32'd1);
    run_op(0, 3'd0, 4'd8, 16'h0, 16'h0, d, ok);
    check("R7 sc value", d, 32'h88);
  endtask

  task automatic t_sc_steal;
    logic [DW-1:0] d; logic ok;
    run_op(3, 3'd5, 4'd10, 16'h0, 16'h0, d, ok);
    run_op(0, 3'd1, 4'd10, 16'h000A, 16'h0, d, ok);
    run_op(3, 3'd6, 4'd10, 16'h000B, 16'h0, d, ok);
    check("R6 sc after foreign store data", d, 32'd0);
    check("R6 sc after foreign store ok", ok, 32'd0);
    run_op(1, 3'd0, 4'd10, 16'h0, 16'h0, d, ok);
    check("R6 memory unchanged", d, 32'hA);
    run_op(3, 3'd5, 4'd10, 16'h0, 16'h0, d, ok);
    run_op(2, 3'd4, 4'd10, 16'h0, 16'h0, d, ok);
    run_op(3, 3'd6, 4'd10, 16'h00CC, 16'h0, d, ok);
    check("R6 sc after foreign increment", d, 32'd0);
    run_op(1, 3'd6, 4'd10, 16'h00DD, 16'h0, d, ok);
    check("R6 sc with no link", d, 32'd0);
    run_op(0, 3'd0, 4'd10, 16'h0, 16'h0, d, ok);
    check("R6 value after failures", d, 32'hB);
  endtask

  task automatic t_rr;
    int prev;
    int gid;
    prev = -1;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      req_op[i*3 +: 3]    = 3'd0;
      req_addr[i*AW +: AW] = 4'd3;
    end
    req_valid = '1;
    for (int k = 0; k < N; k++) begin
      #1;
      while (req_ready == '0) begin
        @(negedge clk);
        #1;
      end
      gid = 0;
      for (int i = 0; i < N; i++) if (req_ready[i]) gid = i;
      if (k > 0) begin
        check("R9 rotation order", gid, (prev + 1) % N);
        check("R9 rsp_id for previous grant", {30'd0, rsp_id}, prev);
        check("R8 rsp with next grant", {31'd0, rsp_valid}, 32'd1);
      end
      prev = gid;
      @(posedge clk);
      #1;
      req_valid[gid] = 1'b0;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    check("R9 last rsp_id", {30'd0, rsp_id}, prev);
    check("R1 rr load data", rsp_data, 32'hBEEF);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = '0;
    req_op    = '0;
    req_addr  = '0;
    req_opa   = '0;
    req_opb   = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_load_store;
    t_cas;
    t_tas;
    t_fai;
    t_sc_ok;
    t_sc_own;
    t_sc_steal;
    t_rr;
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule